// File: doc/BRIEF.md
# Multi-Mode Supervisory Watchdog

This block supervises a host microcontroller. The host configures and services it through a parallel register-write strobe. A write to the control register does three things at once. It restarts the watchdog, selects one of eight periods and picks one of three modes: Window, Timeout or Off. Time is counted in millisecond ticks. A prescaler divides the system clock to make those ticks, and every accepted trigger restarts the prescaler as well, so period boundaries fall a fixed number of clock cycles after the trigger.

In Window mode, each period has two halves. The first half is closed and the second half is open. A Window-mode write that arrives in the closed half is a fault. So is a period that runs out with no write at all. A fault pulls the active-low reset request low for a fixed number of ticks and sets a sticky reset-source flag. In Timeout mode, a period that runs out raises an interrupt request instead; if a request is already pending, nothing new is raised. In Off mode the counter is held and nothing fires. The `sys_normal` output reports that the host has serviced the block in time, which the surrounding system controller uses to leave its start-up state.

The controller has five states:
- `ST_IDLE`: Off mode.
- `ST_CLOSED`: first half of a Window period.
- `ST_OPEN`: second half of a Window period.
- `ST_TOUT`: counting in Timeout mode.
- `ST_PULSE`: reset pulse in progress.

Its transitions are:
- Any control write, in any state except `ST_PULSE`, moves to the entry state of the written mode. Window enters `ST_CLOSED`, Timeout enters `ST_TOUT`, Off enters `ST_IDLE`.
- The exception is a Window-mode write in `ST_CLOSED`, which goes to `ST_PULSE`.
- `ST_CLOSED` moves to `ST_OPEN` at the half-period tick.
- `ST_OPEN` moves to `ST_PULSE` at the full-period tick.
- `ST_TOUT` stays in `ST_TOUT` at the full-period tick, raising the interrupt.
- `ST_PULSE` leaves after the pulse length to the entry state of the stored mode.

Top module: `wdog_supervisor`

## Requirements
- R1: After reset, `rst_req_n` is 1 and `irq`, `rst_src_flag` and `sys_normal` are 0. The mode is Window and the period code is 4 (128 ms).
- R2: The control register (`wr_addr`=0) holds the period code in `wr_data[2:0]`. The codes 0 to 7 select 8, 16, 32, 64, 128, 256, 1024 and 4096 ticks. The mode is in `wr_data[4:3]`: 00 Off, 01 Window, 10 Timeout, 11 Off.
- R3: Every control write accepted outside a reset pulse is a trigger, whatever its data. It restarts the tick prescaler and the period counter from zero. Writes to the status register (`wr_addr`=1) are not triggers.
- R4: In Window mode, a write selecting Window that is sampled fewer than P/2 ticks after the last restart starts a reset pulse at that edge. P is the period.
- R5: In Window mode with no trigger, `rst_req_n` falls exactly P*TICK_DIV clock cycles after the last restart.
- R6: In Timeout mode, expiry after P*TICK_DIV cycles sets the interrupt pending bit, so `irq` rises. The count restarts and no reset is produced.
- R7: An expiry while the interrupt is already pending changes nothing. `irq` stays high until a status write with `wr_data[0]`=1 clears it.
- R8: In Off mode the counter is held, and neither a reset nor an interrupt is produced.
- R9: A reset pulse lasts RST_PULSE_MS ticks. Control writes during the pulse are ignored. Afterwards the block restarts in the stored mode.
- R10: A watchdog reset sets `rst_src_flag`. The flag stays set until a status write with `wr_data[1]`=1 clears it.
- R11: `sys_normal` is set by a trigger in the open half of a Window period, or by any trigger in Timeout mode. It is cleared when a reset pulse starts.
- R12: A new mode and period take effect at the write. A write that selects a mode other than Window is never judged against the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the status register |
| wr_data | input | 5 | Write data: mode and period code, or write-1-to-clear bits |
| rst_req_n | output | 1 | Active-low system reset request |
| irq | output | 1 | Interrupt request; high while the interrupt is pending |
| rst_src_flag | output | 1 | Sticky flag: the last reset came from the watchdog |
| sys_normal | output | 1 | The host has serviced the watchdog in time |

## Verification
The hardest case to reach is a write that lands inside a reset pulse and has to be ignored. From the ports, an ignored write looks the same as an accepted one until the next period has passed. The stimulus lets a Window period run out, writes Timeout mode during the pulse, and then checks that a second reset arrives exactly one Window period after the pulse ends. The suppressed second expiry in Timeout mode is hard to see for the same reason. It is exposed by clearing the pending bit afterwards and checking that `irq` rises again only at the next period boundary.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int PCODE_W = 3;
    localparam int MODE_W  = 2;
    localparam int CNT_W   = 13;
    localparam int NFLAG   = 2;

    localparam logic [PCODE_W-1:0] PCODE_RESET = 3'd4;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF     = 2'b00,
        MD_WINDOW  = 2'b01,
        MD_TIMEOUT = 2'b10,
        MD_SPARE   = 2'b11
    } wd_mode_e;

    localparam wd_mode_e MODE_RESET = MD_WINDOW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSED,
        ST_OPEN,
        ST_TOUT,
        ST_PULSE
    } wd_state_e;

    // period code to tick count
    function automatic logic [CNT_W-1:0] period_ticks(input logic [PCODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            3'd6:    r = CNT_W'(1024);
            3'd7:    r = CNT_W'(4096);
            default: r = CNT_W'(8) << code;
        endcase
        return r;
    endfunction

    // first state after a restart in a given mode
    function automatic wd_state_e entry_state(input wd_mode_e m);
        wd_state_e s;
        unique case (m)
            MD_WINDOW:  s = ST_CLOSED;
            MD_TIMEOUT: s = ST_TOUT;
            default:    s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int TICK_DIV = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = (pre_q == PRE_LAST) && !restart;

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  wd_mode_e             mode_in,
    input  logic [PCODE_W-1:0]   code_in,
    output wd_mode_e             mode,
    output logic [CNT_W-1:0]     period,
    output logic [CNT_W-1:0]     half
);
    logic [PCODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= MODE_RESET;
            code_q <= PCODE_RESET;
        end else if (load) begin
            mode   <= mode_in;
            code_q <= code_in;
        end
    end

    assign period = period_ticks(code_q);
    assign half   = period >> 1;

endmodule

// File: rtl/wdog_status.sv
module wdog_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int RST_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             kick,
    input  wd_mode_e         new_mode,
    input  wd_mode_e         cur_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] half,
    output logic             in_pulse,
    output logic             rst_req_n,
    output logic             fault_evt,
    output logic             expire_evt,
    output logic             sys_normal
);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(RST_TICKS - 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_clr;
    logic             good_kick;

    // next-state and event decode
    always_comb begin
        state_d    = state_q;
        cnt_clr    = 1'b0;
        fault_evt  = 1'b0;
        expire_evt = 1'b0;
        good_kick  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (kick) begin
                    state_d = entry_state(new_mode);
                    cnt_clr = 1'b1;
                end
            end
            ST_CLOSED: begin
                if (kick) begin
                    cnt_clr = 1'b1;
                    if (new_mode == MD_WINDOW) begin
                        state_d   = ST_PULSE;
                        fault_evt = 1'b1;
                    end else begin
                        state_d = entry_state(new_mode);
                    end
                end else if (tick && cnt_q == half - 1'b1) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (kick) begin
                    state_d   = entry_state(new_mode);
                    cnt_clr   = 1'b1;
                    good_kick = 1'b1;
                end else if (tick && cnt_q == period - 1'b1) begin
                    state_d   = ST_PULSE;
                    cnt_clr   = 1'b1;
                    fault_evt = 1'b1;
                end
            end
            ST_TOUT: begin
                if (kick) begin
                    state_d   = entry_state(new_mode);
                    cnt_clr   = 1'b1;
                    good_kick = 1'b1;
                end else if (tick && cnt_q == period - 1'b1) begin
                    cnt_clr    = 1'b1;
                    expire_evt = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tick && cnt_q == PULSE_LAST) begin
                    state_d = entry_state(cur_mode);
                    cnt_clr = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= entry_state(MODE_RESET);
        end else begin
            state_q <= state_d;
        end
    end

    // tick counter, held in Off mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (tick && state_q != ST_IDLE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // service status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_normal <= 1'b0;
        end else if (fault_evt) begin
            sys_normal <= 1'b0;
        end else if (good_kick) begin
            sys_normal <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_pulse  = (state_q == ST_PULSE);
        rst_req_n = (state_q != ST_PULSE);
    end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int TICK_DIV     = 16000,
    parameter int RST_PULSE_MS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [4:0] wr_data,
    output logic       rst_req_n,
    output logic       irq,
    output logic       rst_src_flag,
    output logic       sys_normal
);
    logic             tick;
    logic             in_pulse;
    logic             ctrl_wr;
    logic             stat_wr;
    logic             fault_evt;
    logic             expire_evt;
    wd_mode_e         wr_mode;
    wd_mode_e         cfg_mode;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] flag_clr;

    assign wr_mode  = wd_mode_e'(wr_data[4:3]);
    assign ctrl_wr  = wr_en && !wr_addr && !in_pulse;
    assign stat_wr  = wr_en && wr_addr;
    assign flag_clr = stat_wr ? wr_data[NFLAG-1:0] : '0;

    wdog_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .tick    (tick)
    );

    wdog_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctrl_wr),
        .mode_in (wr_mode),
        .code_in (wr_data[2:0]),
        .mode    (cfg_mode),
        .period  (period),
        .half    (half)
    );

    wdog_fsm #(.RST_TICKS(RST_PULSE_MS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .kick       (ctrl_wr),
        .new_mode   (wr_mode),
        .cur_mode   (cfg_mode),
        .period     (period),
        .half       (half),
        .in_pulse   (in_pulse),
        .rst_req_n  (rst_req_n),
        .fault_evt  (fault_evt),
        .expire_evt (expire_evt),
        .sys_normal (sys_normal)
    );

    wdog_status #(.N(NFLAG)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({fault_evt, expire_evt}),
        .clr   (flag_clr),
        .flags (flags)
    );

    assign irq          = flags[0];
    assign rst_src_flag = flags[1];

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [4:0] wr_data,
    input logic       rst_req_n,
    input logic       irq,
    input logic       rst_src_flag,
    input logic       sys_normal,
    input logic [1:0] cfg_mode
);
    AST_FLAG_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_n) |-> rst_src_flag); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_src_flag && !(wr_en && wr_addr && wr_data[1]) |=> rst_src_flag); // R10

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(wr_en && wr_addr && wr_data[0]) |=> irq); // R7

    AST_OFF_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00) && rst_req_n |=> rst_req_n); // R8

    AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00) && !irq |=> !irq); // R8

    AST_TOUT_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10) && rst_req_n |=> rst_req_n); // R6

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_n) |=> !rst_req_n); // R9

    AST_NORMAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |-> !sys_normal); // R11

endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rst_req_n    (rst_req_n),
    .irq          (irq),
    .rst_src_flag (rst_src_flag),
    .sys_normal   (sys_normal),
    .cfg_mode     (cfg_mode)
);

// File: tb/wdog_supervisor_bench.sv
`timescale 1ns/1ps
module wdog_supervisor_bench;

    localparam int DIV  = 4;
    localparam int RSTP = 3;
    localparam int NVEC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [4:0] wr_data = '0;
    logic       rst_req_n, irq, rst_src_flag, sys_normal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_supervisor #(.TICK_DIV(DIV), .RST_PULSE_MS(RSTP)) u_wdog_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rst_req_n    (rst_req_n),
        .irq          (irq),
        .rst_src_flag (rst_src_flag),
        .sys_normal   (sys_normal)
    );

    // {mode, code, wait cycles, expected rst_req_n, expected irq}
    // trigger lands wait+1 cycles after the restart; 1 tick = 4 cycles (R2)
    localparam logic [22:0] VEC [NVEC] = '{
        {2'b01, 3'd0, 16'd7,  1'b0, 1'b0},  // R4 closed half of 8 ticks
        {2'b01, 3'd0, 16'd23, 1'b1, 1'b0},  // R4 open half
        {2'b01, 3'd0, 16'd39, 1'b0, 1'b0},  // R5 expired, inside pulse
        {2'b01, 3'd1, 16'd19, 1'b0, 1'b0},  // R2 16 ticks, closed
        {2'b01, 3'd1, 16'd49, 1'b1, 1'b0},  // R2 16 ticks, open
        {2'b01, 3'd2, 16'd59, 1'b0, 1'b0},  // R2 32 ticks, closed
        {2'b01, 3'd2, 16'd69, 1'b1, 1'b0},  // R2 32 ticks, open
        {2'b10, 3'd0, 16'd19, 1'b1, 1'b0},  // R6 before expiry
        {2'b10, 3'd0, 16'd39, 1'b1, 1'b1},  // R6 after expiry
        {2'b10, 3'd1, 16'd39, 1'b1, 1'b0},  // R6 16 ticks, before
        {2'b10, 3'd1, 16'd69, 1'b1, 1'b1},  // R6 16 ticks, after
        {2'b00, 3'd0, 16'd99, 1'b1, 1'b0}   // R8 off mode quiet
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic a, input logic [4:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_addr = 1'b0;
        wr_data = '0;
    endtask

    task automatic settle();
        while (!rst_req_n) @(negedge clk);
        reg_wr(1'b0, 5'b00_000);
        reg_wr(1'b1, 5'b00011);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..: actual hang expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rst_req_n", rst_req_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 rst_src_flag", rst_src_flag, 0);
        chk("R1 sys_normal", sys_normal, 0);

        // R1/R5 default window of 128 ticks expires at edge 512
        wait_cyc(511);
        chk("R5 before default expiry", rst_req_n, 1);
        wait_cyc(1);
        chk("R5 default expiry", rst_req_n, 0);
        chk("R10 flag set", rst_src_flag, 1);
        chk("R11 normal cleared", sys_normal, 0);
        wait_cyc(11);
        chk("R9 pulse still low", rst_req_n, 0);
        wait_cyc(1);
        chk("R9 pulse ended", rst_req_n, 1);

        // R10 W1C and R3 status writes are not triggers
        reg_wr(1'b1, 5'b00001);
        chk("R10 flag kept", rst_src_flag, 1);
        reg_wr(1'b1, 5'b00010);
        chk("R10 flag cleared", rst_src_flag, 0);
        wait_cyc(509);
        chk("R3 no restart by status write", rst_req_n, 1);
        wait_cyc(1);
        chk("R3 expiry unchanged", rst_req_n, 0);
        wait_cyc(12);
        chk("R9 restart after pulse", rst_req_n, 1);

        // R12 leaving window in closed half is not judged
        reg_wr(1'b0, 5'b00_000);
        wait_cyc(40);
        chk("R12 exit window unjudged", rst_req_n, 1);
        // R11 well-timed trigger in open half
        reg_wr(1'b0, 5'b01_000);
        wait_cyc(19);
        reg_wr(1'b0, 5'b01_000);
        chk("R11 open-half trigger ok", rst_req_n, 1);
        chk("R11 normal set", sys_normal, 1);
        settle();

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  vm;
            logic [2:0]  vc;
            logic [15:0] vw;
            {vm, vc, vw} = VEC[i][22:2];
            reg_wr(1'b0, 5'b00_000);
            reg_wr(1'b0, {vm, vc});
            wait_cyc(int'(vw));
            reg_wr(1'b0, {vm, vc});
            chk(vm == 2'b01 ? "R4/R5 table rst" : (vm == 2'b10 ? "R6 table rst" : "R8 table rst"),
                rst_req_n, VEC[i][1]);
            chk(vm == 2'b10 ? "R6 table irq" : "R8 table irq", irq, VEC[i][0]);
            settle();
        end

        // R12 period change restarts and applies at once
        reg_wr(1'b0, 5'b10_000);
        wait_cyc(27);
        reg_wr(1'b0, 5'b10_001);
        chk("R11 timeout trigger", sys_normal, 1);
        wait_cyc(40);
        chk("R12 old period gone", irq, 0);
        wait_cyc(23);
        chk("R12 before new expiry", irq, 0);
        wait_cyc(1);
        chk("R6 new expiry", irq, 1);
        wait_cyc(70);
        chk("R7 second expiry while pending", irq, 1);
        reg_wr(1'b1, 5'b00010);
        chk("R7 clear of other bit", irq, 1);
        reg_wr(1'b1, 5'b00001);
        chk("R7 pending cleared", irq, 0);
        wait_cyc(55);
        chk("R7 no early re-raise", irq, 0);
        wait_cyc(1);
        chk("R6 next expiry", irq, 1);
        chk("R6 no reset", rst_req_n, 1);
        settle();

        // R9 control write inside pulse is ignored
        reg_wr(1'b0, 5'b01_000);
        wait_cyc(33);
        chk("R5 window expiry", rst_req_n, 0);
        chk("R11 normal cleared by reset", sys_normal, 0);
        reg_wr(1'b0, 5'b10_000);
        wait_cyc(9);
        chk("R9 pulse low", rst_req_n, 0);
        wait_cyc(1);
        chk("R9 pulse length", rst_req_n, 1);
        wait_cyc(31);
        chk("R9 still window", rst_req_n, 1);
        wait_cyc(1);
        chk("R9 ignored write", rst_req_n, 0);
        settle();

        done = 1'b1;
        summary();
    end

endmodule